// File: doc/BRIEF.md
# MDIO Register Access Bridge

This block lets host software reach the management registers of an Ethernet PHY through one 32-bit access word. A host store to the word launches a clause 22 management frame on the MDC/MDIO pair. The host then polls the same word until a completion flag flips, and on a read it takes the returned value from the low half. The bridge builds the whole serial frame itself: preamble, start and opcode bits, a fixed PHY address set by parameter, the register number, turnaround and sixteen data bits. It produces MDC with a clock divider that stops when the bridge is idle.

The top bit of the word acts both as the operation selector and as the completion flag, and its polarity depends on the operation. A store with the top bit set means "write". The bit then stays 1 while the frame runs and drops to 0 when the frame ends. A store with the top bit clear means "read". The bit stays 0 until the sixteen data bits are captured and then rises to 1. Stores that arrive while a frame is in progress have no effect.

Top module: `mdio_bridge`

## Requirements
- R1: After synchronous reset the access word reads 0, MDC is low and the MDIO output enable is low.
- R2: A store with bit 31 = 1 sends, MSB first on the wire with a new bit after each MDC falling edge: 32 ones, start 01, opcode 01, the 5-bit PHY address, the register number from bits [20:16], turnaround 10, then bits [15:0]. MDIO is driven for all 64 bits.
- R3: After a write store, bit 31 reads 1 from the next cycle until the frame ends and then reads 0. The word then reads back {0, ten zeros, register number, data}.
- R4: A store with bit 31 = 0 sends 32 ones, start 01, opcode 10, the PHY address and the register number, all driven. MDIO is released (output enable low) from the first turnaround bit (bit 46 of the frame) to the end of the frame.
- R5: During a read, the 16 bits after turnaround are sampled from MDIO on the rising edges of MDC, MSB first. Bit 31 reads 0 until capture is complete and then reads 1. Bits [15:0] then hold the captured value and bits [20:16] hold the register number.
- R6: A store that arrives while a frame is in progress is ignored. The access word and the frame on the wire do not change, and no further frame follows.
- R7: MDC stays high and low for HALF_CYC system clocks each. By default HALF_CYC is derived so that MDC does not exceed 2.5 MHz (50 clocks at 250 MHz). MDC is low whenever the bridge is idle.
- R8: The completion flag changes state exactly 128*HALF_CYC+1 clock edges after the edge that accepts the store, which is about 26 us at the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr_en | input | 1 | Store strobe for the access word |
| acc_wr_data | input | 32 | Value stored: bit 31 operation/flag, [20:16] register, [15:0] data |
| acc_rd_data | output | 32 | Current access word value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Management data driven towards the PHY |
| mdio_oe | output | 1 | Drive enable for mdio_out |
| mdio_in | input | 1 | Management data returned from the PHY |

## Verification
A wrong bit counter or shift register shows up on the wire within one MDC period, as a wrong preamble, opcode or address bit, or as the output enable released at the wrong bit. It shows at the access word only at the end of the frame, as corrupted read data or a flag that flips early or late. A wrong busy or flag state shows at the access word one cycle after the store: the flag has the wrong polarity, or a rejected store overwrites the register field. It also shows later as a missing or extra burst of MDC pulses. So the bench captures every bit on each MDC rising edge, times the flag change to the exact cycle, and watches MDC after completion for stray frames.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // access word layout (host-visible; polarity of the flag depends on the op)
  localparam int ACC_W    = 32;
  localparam int FLAG_BIT = 31;
  localparam int RAW      = 5;   // register-number width
  localparam int PAW      = 5;   // PHY-address width
  localparam int DW       = 16;  // data width
  localparam int REG_LSB  = 16;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } mdio_op_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign wrap      = en && (cnt == LAST);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  // R7
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mdc);
  // R7
  mdc_rise_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (en && rise_tick) |=> mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int          PRE_BITS = 32,
  parameter logic [PAW-1:0] PHY_ADDR = 5'h01
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  mdio_op_e       start_op,
  input  logic [RAW-1:0] start_reg,
  input  logic [DW-1:0]  start_data,
  input  logic           rise_tick,
  input  logic           fall_tick,
  input  logic           mdc,
  output logic           busy,
  output logic           done,
  output logic [DW-1:0]  cap_data,
  output logic           mdio_out,
  output logic           mdio_oe,
  input  logic           mdio_in
);
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PAW + RAW + 2 + DW;
  localparam int TA_IDX     = PRE_BITS + 4 + PAW + RAW;
  localparam int DATA_IDX   = TA_IDX + 2;
  localparam int IW         = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] frame_w;
  logic [IW-1:0]         bit_idx;
  logic                  is_read;
  logic                  wr_op;

  assign wr_op   = (start_op == OP_WRITE);
  assign frame_w = {{PRE_BITS{1'b1}}, 2'b01,
                    wr_op ? 2'b01 : 2'b10,
                    PHY_ADDR, start_reg,
                    wr_op ? 2'b10 : 2'b11,
                    wr_op ? start_data : {DW{1'b1}}};

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      busy     <= 1'b0;
      is_read  <= 1'b0;
      bit_idx  <= '0;
      shreg    <= '1;
      mdio_oe  <= 1'b0;
      cap_data <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        is_read <= !wr_op;
        bit_idx <= '0;
        shreg   <= frame_w;
        mdio_oe <= 1'b1;
      end
    end else begin
      if (rise_tick && is_read && int'(bit_idx) >= DATA_IDX)
        cap_data <= {cap_data[DW-2:0], mdio_in};
      if (fall_tick) begin
        if (bit_idx == LAST_IDX) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          shreg   <= {shreg[FRAME_BITS-2:0], 1'b1};
          mdio_oe <= !(is_read && (int'(bit_idx) + 1 >= TA_IDX));
        end
      end
    end
  end

  assign mdio_out = shreg[FRAME_BITS-1];

  // R2
  preamble_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && int'(bit_idx) < PRE_BITS) |-> (mdio_out && mdio_oe));
  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && is_read && int'(bit_idx) >= TA_IDX) |-> !mdio_oe);
  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && mdc && !fall_tick) |=> $stable(mdio_out));
endmodule

// File: rtl/mdio_access_reg.sv
module mdio_access_reg
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ACC_W-1:0] wr_data,
  output logic [ACC_W-1:0] rd_data,
  output logic             start,
  output mdio_op_e         start_op,
  output logic [RAW-1:0]   start_reg,
  output logic [DW-1:0]    start_data,
  input  logic             done,
  input  logic [DW-1:0]    cap_data
);
  localparam int PAD_W = FLAG_BIT - RAW - DW;

  logic           busy_q;
  logic           flag_q;
  mdio_op_e       op_q;
  logic [RAW-1:0] addr_q;
  logic [DW-1:0]  data_q;
  logic           unused_bits;

  assign unused_bits = ^wr_data[FLAG_BIT-1:REG_LSB+RAW];
  assign start       = wr_en && !busy_q;
  assign start_op    = mdio_op_e'(wr_data[FLAG_BIT]);
  assign start_reg   = wr_data[REG_LSB +: RAW];
  assign start_data  = wr_data[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      flag_q <= 1'b0;
      op_q   <= OP_READ;
      addr_q <= '0;
      data_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      op_q   <= start_op;
      flag_q <= wr_data[FLAG_BIT];
      addr_q <= start_reg;
      data_q <= start_data;
    end else if (done) begin
      busy_q <= 1'b0;
      if (op_q == OP_WRITE) begin
        flag_q <= 1'b0;
      end else begin
        flag_q <= 1'b1;
        data_q <= cap_data;
      end
    end
  end

  assign rd_data = {flag_q, {PAD_W{1'b0}}, addr_q, data_q};

  // R6
  ignore_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && wr_en && !done) |=> ($stable(addr_q) && $stable(flag_q) && busy_q));
  // R3
  write_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (done && busy_q && op_q == OP_WRITE) |=> !flag_q);
  // R5
  read_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (done && busy_q && op_q == OP_READ) |=> flag_q);
  // R3
  write_flag_up_chk: assert property (@(posedge clk) disable iff (rst)
    (start && wr_data[FLAG_BIT]) |=> (flag_q && busy_q));
endmodule

// File: rtl/mdio_bridge.sv
module mdio_bridge
  import mdio_pkg::*;
#(
  parameter int             CLK_HZ   = 250_000_000,
  parameter int             MDC_HZ   = 2_500_000,
  parameter int             HALF_CYC = (CLK_HZ + 2*MDC_HZ - 1) / (2*MDC_HZ),
  parameter int             PRE_BITS = 32,
  parameter logic [PAW-1:0] PHY_ADDR = 5'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_wr_en,
  input  logic [ACC_W-1:0] acc_wr_data,
  output logic [ACC_W-1:0] acc_rd_data,
  output logic             mdc,
  output logic             mdio_out,
  output logic             mdio_oe,
  input  logic             mdio_in
);
  logic           start, busy, done, rise_tick, fall_tick;
  mdio_op_e       start_op;
  logic [RAW-1:0] start_reg;
  logic [DW-1:0]  start_data, cap_data;

  mdio_access_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(acc_wr_en), .wr_data(acc_wr_data),
    .rd_data(acc_rd_data), .start(start), .start_op(start_op),
    .start_reg(start_reg), .start_data(start_data),
    .done(done), .cap_data(cap_data)
  );

  mdio_clk_div #(.HALF_CYC(HALF_CYC)) u_div (
    .clk(clk), .rst(rst), .en(busy), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine #(.PRE_BITS(PRE_BITS), .PHY_ADDR(PHY_ADDR)) u_eng (
    .clk(clk), .rst(rst), .start(start), .start_op(start_op),
    .start_reg(start_reg), .start_data(start_data),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdc(mdc),
    .busy(busy), .done(done), .cap_data(cap_data),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );
endmodule

// File: tb/mdio_bridge_tb_top.sv
`timescale 1ns/1ps
module mdio_bridge_tb_top;
  localparam int HALF   = 50;
  localparam int OP_CYC = 128*HALF + 1;
  localparam logic [4:0] PHY = 5'h01;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_wr_en = 1'b0;
  logic [31:0] acc_wr_data = '0;
  logic [31:0] acc_rd_data;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mdio_bridge dut_i (
    .clk(clk), .rst(rst), .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
    .acc_rd_data(acc_rd_data), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  // PHY model: record each bit on the MDC rising edge, present next read bit
  int          rise_n = 0;
  logic [63:0] cap_out, cap_oe;
  logic [15:0] rd_pat = '0;

  always @(posedge mdc) begin
    if (rise_n < 64) begin
      cap_out[63-rise_n] = mdio_out;
      cap_oe[63-rise_n]  = mdio_oe;
    end
    rise_n = rise_n + 1;
    mdio_in = (rise_n >= 48 && rise_n < 64) ? rd_pat[63-rise_n] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // store a word, report flag at first sample and cycles until it changes
  task automatic run_op(input logic [31:0] w, output logic flag0, output int lat);
    rise_n = 0;
    @(negedge clk);
    acc_wr_en = 1'b1;
    acc_wr_data = w;
    @(negedge clk);
    acc_wr_en = 1'b0;
    flag0 = acc_rd_data[31];
    lat = 0;
    while (acc_rd_data[31] == flag0 && lat < OP_CYC + 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(acc_rd_data == 32'h0, "R1 word", 64'(acc_rd_data), 64'h0);
    chk(mdc == 1'b0, "R1 mdc", 64'(mdc), 64'h0);
    chk(mdio_oe == 1'b0, "R1 oe", 64'(mdio_oe), 64'h0);
  endtask

  task automatic t_write(input logic [4:0] ra, input logic [15:0] d);
    logic f0; int lat;
    run_op({1'b1, 10'b0, ra, d}, f0, lat);
    chk(f0 == 1'b1, "R3 flag busy", 64'(f0), 64'h1);
    chk(lat == OP_CYC, "R8 write latency", 64'(lat), 64'(OP_CYC));
    chk(acc_rd_data == {1'b0, 10'b0, ra, d}, "R3 readback", 64'(acc_rd_data),
        64'({1'b0, 10'b0, ra, d}));
    chk(cap_out == {32'hFFFF_FFFF, 2'b01, 2'b01, PHY, ra, 2'b10, d}, "R2 frame",
        cap_out, {32'hFFFF_FFFF, 2'b01, 2'b01, PHY, ra, 2'b10, d});
    chk(cap_oe == '1, "R2 drive", cap_oe, '1);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R7 idle", 64'({mdc, mdio_oe}), 64'h0);
  endtask

  task automatic t_read(input logic [4:0] ra, input logic [15:0] pat);
    logic f0; int lat;
    rd_pat = pat;
    run_op({1'b0, 10'b0, ra, 16'h5A5A}, f0, lat);
    chk(f0 == 1'b0, "R5 flag busy", 64'(f0), 64'h0);
    chk(lat == OP_CYC, "R8 read latency", 64'(lat), 64'(OP_CYC));
    chk(acc_rd_data == {1'b1, 10'b0, ra, pat}, "R5 data", 64'(acc_rd_data),
        64'({1'b1, 10'b0, ra, pat}));
    chk(cap_out[63:18] == {32'hFFFF_FFFF, 2'b01, 2'b10, PHY, ra}, "R4 header",
        64'(cap_out[63:18]), 64'({32'hFFFF_FFFF, 2'b01, 2'b10, PHY, ra}));
    chk(cap_oe == {{46{1'b1}}, 18'b0}, "R4 release", cap_oe, {{46{1'b1}}, 18'b0});
  endtask

  task automatic t_busy_ignore();
    logic [31:0] w1;
    w1 = {1'b1, 10'b0, 5'h0A, 16'hC0DE};
    rise_n = 0;
    @(negedge clk); acc_wr_en = 1'b1; acc_wr_data = w1;
    @(negedge clk); acc_wr_en = 1'b0;
    repeat (200) @(negedge clk);
    acc_wr_en = 1'b1; acc_wr_data = {1'b0, 10'b0, 5'h15, 16'h1234};
    @(negedge clk); acc_wr_en = 1'b0;
    @(negedge clk);
    chk(acc_rd_data == w1, "R6 word kept", 64'(acc_rd_data), 64'(w1));
    for (int i = 0; i < OP_CYC + 50 && acc_rd_data[31]; i++) @(negedge clk);
    chk(acc_rd_data == {1'b0, 10'b0, 5'h0A, 16'hC0DE}, "R6 completion",
        64'(acc_rd_data), 64'({1'b0, 10'b0, 5'h0A, 16'hC0DE}));
    chk(cap_out == {32'hFFFF_FFFF, 4'b0101, PHY, 5'h0A, 2'b10, 16'hC0DE},
        "R6 frame", cap_out, {32'hFFFF_FFFF, 4'b0101, PHY, 5'h0A, 2'b10, 16'hC0DE});
    repeat (4*HALF) @(negedge clk);
    chk(rise_n == 64, "R6 no second frame", 64'(rise_n), 64'd64);
  endtask

  task automatic t_mdc_period();
    int hi;
    rise_n = 0;
    @(negedge clk); acc_wr_en = 1'b1; acc_wr_data = {1'b1, 10'b0, 5'h03, 16'h0F0F};
    @(negedge clk); acc_wr_en = 1'b0;
    chk(mdc == 1'b0, "R7 starts low", 64'(mdc), 64'h0);
    while (!mdc) @(negedge clk);
    hi = 0;
    while (mdc) begin @(negedge clk); hi++; end
    chk(hi == HALF, "R7 high time", 64'(hi), 64'(HALF));
    chk(250_000_000 / (2*hi) <= 2_500_000, "R7 max rate",
        64'(250_000_000 / (2*hi)), 64'd2_500_000);
    for (int i = 0; i < OP_CYC + 50 && acc_rd_data[31]; i++) @(negedge clk);
    chk(acc_rd_data[31] == 1'b0, "R3 done", 64'(acc_rd_data[31]), 64'h0);
  endtask

  initial begin
    t_reset();
    t_write(5'h1F, 16'h8001);
    t_write(5'h00, 16'h0000);
    t_read(5'h04, 16'hA5C3);
    t_read(5'h11, 16'h8000);
    t_write(5'h09, 16'h0200);
    t_read(5'h01, 16'h0001);
    t_busy_ignore();
    t_mdc_period();
    t_reset();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 190_000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule